// File: doc/BRIEF.md
# Block Cipher Register Front End

This block sits between a 32-bit memory-mapped slave bus and a 128-bit block cipher engine that lives elsewhere on the chip. Software fills a key bank and a four-word data bank through ordinary word writes. It then writes a control word that launches an encryption or a decryption. The block hands the key, the data and the direction to the engine, stalls the bus while the engine runs, captures the 128-bit answer when the engine signals done, and raises an interrupt if software asked for one.

The key stays loaded across any number of operations. Software can therefore encrypt a stream of blocks under one key and only rewrite the data bank. A control write with the key-valid bit clear withdraws the key from the engine, and no operation can start until a later control write marks it valid again. The key length is a parameter (128, 192 or 256 bits). Key words beyond that length are not stored.

Top module: `crx_regif`

## Requirements
- R1: After reset, irq, wait_req, eng_start and eng_key_valid are low, and reads of the result words and of the control word return zero.
- R2: Key words are written at addresses 0 to KEY_BITS/32-1, and the word at address 0 forms the most significant 32 bits of eng_key. Writes to the other addresses of the 0 to 7 range change nothing.
- R3: The four data words are written at addresses 8 to 11, and address 8 forms the most significant 32 bits of eng_din.
- R4: The control word is at address 31. Bit 7 is key valid, bit 6 is interrupt enable, and bits 1:0 select the operation: 01 encrypt, 10 decrypt, 00 and 11 none. A control write with bit 7 set and operation 01 or 10 pulses eng_start for exactly one cycle, starting the cycle after the write, with eng_decrypt high only for 10. So 0xC1 encrypts and 0xC2 decrypts.
- R5: A control write with bit 7 clear drops eng_key_valid, and it starts nothing even if its operation field asks for one.
- R6: On the cycle eng_done is high during an operation, eng_result is captured. It is read back at addresses 16 to 19, most significant word at 16. rdata is loaded on the clock edge that accepts the read.
- R7: irq rises when an operation completes with interrupt enable set, and stays low when that bit is clear. It stays high until an accepted control write or an accepted read of a result word.
- R8: While an operation runs, wait_req is high for every access. A held write reaches its register only after the engine reports done, so the running operation sees unchanged key and data.
- R9: Key and data persist across operations. Repeating an operation without rewriting anything presents the same inputs to the engine, and new data needs no key reload.
- R10: Reads of key and data addresses return zero, and a read of address 31 returns key valid in bit 7 and interrupt enable in bit 6, with other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Slave select |
| addr | input | AW | Word address |
| wr | input | 1 | Write request |
| rd | input | 1 | Read request |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| wait_req | output | 1 | Stall: access not accepted this cycle |
| irq | output | 1 | Completion interrupt |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_decrypt | output | 1 | Direction for the launched operation |
| eng_key_valid | output | 1 | Key bank holds a validated key |
| eng_key | output | KEY_BITS | Key, first word most significant |
| eng_din | output | BLK_BITS | Input block, first word most significant |
| eng_done | input | 1 | Engine finished, result valid this cycle |
| eng_result | input | BLK_BITS | Engine output block |

## Verification
The hardest situation to reach is a bus access that collides with an operation in flight. The write must stall and then land only after completion, with the running operation still seeing the old block. The bench's engine stub has a programmable latency, so the operation can be held open for several cycles while a data write is issued and the number of stalled cycles is counted. The sweep also varies latency from one to five cycles and changes key, data, direction and interrupt enable on different periods. This covers repeated runs, data-only updates and fresh keys after invalidation.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int unsigned CRX_KEY_SLOTS = 8;
  localparam int unsigned CRX_DATA_BASE = 8;
  localparam int unsigned CRX_RES_BASE  = 16;
  localparam int unsigned CRX_CTRL_ADDR = 31;
  localparam int unsigned CB_KEYV       = 7;
  localparam int unsigned CB_IRQEN      = 6;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_ENC  = 2'b01,
    OP_DEC  = 2'b10,
    OP_RSV  = 2'b11
  } crx_op_e;
endpackage

// File: rtl/crx_word_bank.sv
module crx_word_bank #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int BASE  = 0,
  localparam int FW   = WORDS * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [FW-1:0] words
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [AW-1:0] SLOT = AW'(BASE + i);
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                     q <= '0;
      else if (we && addr == SLOT) q <= wdata;
    end
    // first slot lands in the most significant word
    assign words[(WORDS-1-i)*DW +: DW] = q;
  end
endmodule

// File: rtl/crx_seq.sv
module crx_seq
  import crx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_op,
  input  logic       ctrl_keyv,
  input  logic       ctrl_ie,
  input  logic       res_rd,
  input  logic       eng_done,
  output logic       busy,
  output logic       eng_start,
  output logic       eng_decrypt,
  output logic       key_valid,
  output logic       irq_en,
  output logic       irq,
  output logic       capture
);
  crx_op_e op;
  logic    go;

  assign op      = crx_op_e'(ctrl_op);
  assign go      = ctrl_we & ctrl_keyv & ((op == OP_ENC) | (op == OP_DEC));
  assign capture = busy & eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      eng_start   <= 1'b0;
      eng_decrypt <= 1'b0;
      key_valid   <= 1'b0;
      irq_en      <= 1'b0;
      irq         <= 1'b0;
    end else begin
      eng_start <= go;
      if (ctrl_we) begin
        key_valid <= ctrl_keyv;
        irq_en    <= ctrl_ie;
        irq       <= 1'b0;
        if (go) begin
          busy        <= 1'b1;
          eng_decrypt <= (op == OP_DEC);
        end
      end else if (capture) begin
        busy <= 1'b0;
        irq  <= irq_en;
      end else if (res_rd) begin
        irq <= 1'b0;
      end
    end
  end

  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  a_r4_start_marks_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy);
  a_r5_start_needs_key: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> key_valid);
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_en);
  a_r7_irq_idle_only: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);
endmodule

// File: rtl/crx_regif.sv
module crx_regif
  import crx_pkg::*;
#(
  parameter int KEY_BITS  = 256,
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int BLK_BITS  = 128,
  localparam int KEY_WORDS = KEY_BITS / DW,
  localparam int BLK_WORDS = BLK_BITS / DW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  logic [AW-1:0]       addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                wait_req,
  output logic                irq,
  output logic                eng_start,
  output logic                eng_decrypt,
  output logic                eng_key_valid,
  output logic [KEY_BITS-1:0] eng_key,
  output logic [BLK_BITS-1:0] eng_din,
  input  logic                eng_done,
  input  logic [BLK_BITS-1:0] eng_result
);
  localparam logic [AW-1:0] CTRL_A = AW'(CRX_CTRL_ADDR);
  localparam logic [AW-1:0] RES_LO = AW'(CRX_RES_BASE);
  localparam logic [AW-1:0] RES_HI = AW'(CRX_RES_BASE + BLK_WORDS - 1);

  logic busy, capture, irq_en;
  logic acc_wr, acc_rd, ctrl_hit, res_hit, res_rd;
  logic [AW-1:0]       roff;
  logic [DW-1:0]       rsel, ctrl_rb;
  logic [BLK_BITS-1:0] res_q;

  assign wait_req = cs & (rd | wr) & busy;
  assign acc_wr   = cs & wr & ~busy;
  assign acc_rd   = cs & rd & ~wr & ~busy;
  assign ctrl_hit = (addr == CTRL_A);
  assign res_hit  = (addr >= RES_LO) && (addr <= RES_HI);
  assign res_rd   = acc_rd & res_hit;
  assign roff     = addr - RES_LO;

  crx_word_bank #(.WORDS(KEY_WORDS), .DW(DW), .AW(AW), .BASE(0)) u_key (
    .clk(clk), .rst(rst), .we(acc_wr), .addr(addr), .wdata(wdata), .words(eng_key));

  crx_word_bank #(.WORDS(BLK_WORDS), .DW(DW), .AW(AW), .BASE(CRX_DATA_BASE)) u_data (
    .clk(clk), .rst(rst), .we(acc_wr), .addr(addr), .wdata(wdata), .words(eng_din));

  crx_seq u_seq (
    .clk(clk), .rst(rst),
    .ctrl_we(acc_wr & ctrl_hit), .ctrl_op(wdata[1:0]),
    .ctrl_keyv(wdata[CB_KEYV]), .ctrl_ie(wdata[CB_IRQEN]),
    .res_rd(res_rd), .eng_done(eng_done),
    .busy(busy), .eng_start(eng_start), .eng_decrypt(eng_decrypt),
    .key_valid(eng_key_valid), .irq_en(irq_en), .irq(irq), .capture(capture));

  always_ff @(posedge clk) begin
    if (rst)          res_q <= '0;
    else if (capture) res_q <= eng_result;
  end

  always_comb begin
    rsel = '0;
    for (int j = 0; j < BLK_WORDS; j++)
      if (roff == AW'(j)) rsel = res_q[(BLK_WORDS-1-j)*DW +: DW];
  end

  always_comb begin
    ctrl_rb           = '0;
    ctrl_rb[CB_KEYV]  = eng_key_valid;
    ctrl_rb[CB_IRQEN] = irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (acc_rd) begin
      if (res_hit)       rdata <= rsel;
      else if (ctrl_hit) rdata <= ctrl_rb;
      else               rdata <= '0;
    end
  end

  a_r8_wait_only_busy: assert property (@(posedge clk) disable iff (rst)
    wait_req |-> busy);
  a_r8_inputs_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> ($stable(eng_din) && $stable(eng_key)));
  a_r6_result_captured: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done) |=> (res_q == $past(eng_result)));
endmodule

// File: tb/crx_regif_tb.sv
module crx_regif_tb;
  localparam int KB = 192;
  localparam int KW = KB / 32;

  logic clk = 1'b0, rst = 1'b1;
  logic cs = 0, wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic wait_req, irq, eng_start, eng_decrypt, eng_key_valid, eng_done;
  logic [KB-1:0] eng_key;
  logic [127:0] eng_din, eng_result;

  int n_chk = 0, n_fail = 0;
  int lat_cfg = 1, start_cnt = 0, done_cnt = 0;
  logic [KB-1:0] cap_key;
  logic [127:0] cap_din;
  logic cap_dec;
  logic [31:0] kw [8];
  logic [31:0] dw [4];

  always #5 clk = ~clk;

  crx_regif #(.KEY_BITS(KB)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .wait_req(wait_req), .irq(irq), .eng_start(eng_start),
    .eng_decrypt(eng_decrypt), .eng_key_valid(eng_key_valid), .eng_key(eng_key),
    .eng_din(eng_din), .eng_done(eng_done), .eng_result(eng_result));

  function automatic logic [127:0] fmodel(logic [KB-1:0] k, logic [127:0] d, logic dec);
    logic [127:0] fold;
    fold = k[127:0] ^ {k[KB-1:128], k[KB-1:128]};
    return dec ? (d - fold) : ({d[95:0], d[127:96]} ^ fold);
  endfunction

  function automatic logic [KB-1:0] key_vec();
    logic [KB-1:0] v = '0;
    for (int i = 0; i < KW; i++) v[(KW-1-i)*32 +: 32] = kw[i];
    return v;
  endfunction

  function automatic logic [127:0] data_vec();
    return {dw[0], dw[1], dw[2], dw[3]};
  endfunction

  // engine stub
  initial begin
    eng_done = 1'b0; eng_result = '0;
    forever begin
      @(negedge clk);
      if (eng_start === 1'b1) begin
        start_cnt++;
        cap_key = eng_key; cap_din = eng_din; cap_dec = eng_decrypt;
        repeat (lat_cfg - 1) @(negedge clk);
        eng_result = fmodel(cap_key, cap_din, cap_dec);
        eng_done = 1'b1;
        done_cnt++;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic report_end();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=hung exp=done");
    report_end();
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    cs = 1; wr = 1; rd = 0; addr = a; wdata = d; waits = 0;
    #1;
    while (wait_req) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    cs = 1; rd = 1; wr = 0; addr = a; waits = 0;
    #1;
    while (wait_req) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    d = rdata; cs = 0; rd = 0;
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    int w;
    bus_write(a, d, w);
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    int w;
    bus_read(a, d, w);
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_key(input int seed);
    for (int i = 0; i < 8; i++) begin
      kw[i] = (32'(seed + 1) * 32'h9E3779B9) ^ {4{8'(i)}};
      wreg(5'(i), kw[i]);
    end
    chk("R2 key bank order, slots 6-7 dropped", 256'(eng_key), 256'(key_vec()));
  endtask

  task automatic load_data(input int seed);
    for (int j = 0; j < 4; j++) begin
      dw[j] = {8'(seed), 8'(j), 16'hA5C3 ^ 16'(seed * 131)};
      wreg(5'(8 + j), dw[j]);
    end
    chk("R3 data bank order", 256'(eng_din), 256'(data_vec()));
  endtask

  task automatic run_op(input logic dec, input logic ie);
    int target;
    logic [127:0] exp;
    logic [31:0] v;
    target = done_cnt + 1;
    wreg(5'd31, {24'h0, 1'b1, ie, 4'h0, dec ? 2'b10 : 2'b01});
    chk("R4 start pulse", 256'(eng_start), 256'(1));
    chk("R4 direction", 256'(eng_decrypt), 256'(dec));
    @(negedge clk);
    chk("R4 start lasts one cycle", 256'(eng_start), 256'(0));
    wait_done(target);
    chk("R9 key at engine", 256'(cap_key), 256'(key_vec()));
    chk("R9 data at engine", 256'(cap_din), 256'(data_vec()));
    chk("R7 irq on completion", 256'(irq), 256'(ie));
    exp = fmodel(key_vec(), data_vec(), dec);
    for (int j = 0; j < 4; j++) begin
      rreg(5'(16 + j), v);
      chk("R6 result word", 256'(v), 256'(exp[(3-j)*32 +: 32]));
      if (j == 0) chk("R7 irq cleared by result read", 256'(irq), 256'(0));
    end
  endtask

  initial begin
    logic [31:0] v;
    int w, s0, target;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 irq after reset", 256'(irq), 256'(0));
    chk("R1 wait_req after reset", 256'(wait_req), 256'(0));
    chk("R1 start after reset", 256'(eng_start), 256'(0));
    chk("R1 key_valid after reset", 256'(eng_key_valid), 256'(0));
    rreg(5'd16, v); chk("R1 result after reset", 256'(v), 256'(0));
    rreg(5'd31, v); chk("R1 control after reset", 256'(v), 256'(0));

    for (int it = 0; it < 12; it++) begin
      lat_cfg = 1 + it % 5;
      if (it % 4 == 0) begin
        if (it > 0) begin
          wreg(5'd31, 32'h0);
          chk("R5 key withdrawn", 256'(eng_key_valid), 256'(0));
          s0 = start_cnt;
          wreg(5'd31, 32'h41);
          repeat (3) @(negedge clk);
          chk("R5 start without key ignored", 256'(start_cnt), 256'(s0));
          rreg(5'd31, v);
          chk("R10 control readback", 256'(v), 256'(32'h40));
        end
        load_key(it);
      end
      if (it % 3 != 2) load_data(it);
      run_op(it[0], (it % 6) != 5);
    end

    // control write clears irq, idle op starts nothing
    lat_cfg = 2;
    target = done_cnt + 1;
    wreg(5'd31, 32'hC1);
    wait_done(target);
    chk("R7 irq before control write", 256'(irq), 256'(1));
    s0 = start_cnt;
    wreg(5'd31, 32'hC0);
    chk("R7 irq cleared by control write", 256'(irq), 256'(0));
    repeat (2) @(negedge clk);
    chk("R4 idle op starts nothing", 256'(start_cnt), 256'(s0));
    rreg(5'd31, v); chk("R10 control readback keyv+ie", 256'(v), 256'(32'hC0));

    // write collides with running operation
    lat_cfg = 6;
    target = done_cnt + 1;
    wreg(5'd31, 32'hC2);
    bus_write(5'd8, 32'hDEADBEEF, w);
    chk("R8 write stalled", 256'(w > 0), 256'(1));
    wait_done(target);
    chk("R8 running op saw old data", 256'(cap_din), 256'(data_vec()));
    rreg(5'd16, v);
    chk("R8 result from old data", 256'(v), 256'(fmodel(key_vec(), data_vec(), 1'b1) >> 96));
    dw[0] = 32'hDEADBEEF;
    chk("R8 held write landed", 256'(eng_din), 256'(data_vec()));
    lat_cfg = 4;
    wreg(5'd31, 32'hC1);
    bus_read(5'd31, v, w);
    chk("R8 read stalled", 256'(w > 0), 256'(1));
    chk("R8 stalled read value", 256'(v), 256'(32'hC0));
    run_op(1'b0, 1'b1);

    rreg(5'd0, v);  chk("R10 key not readable", 256'(v), 256'(0));
    rreg(5'd9, v);  chk("R10 data reads zero", 256'(v), 256'(0));
    report_end();
  end
endmodule